// File: doc/BRIEF.md
# GPIO Pin Multiplexer Bank

This block serves a group of general-purpose pins. Each pin carries a 2-bit function select. With code 00 the pin is plain GPIO: its pad output comes from a data latch and its output enable from a direction latch. With one of the other three codes, the pin is handed to one of three peripheral functions. That peripheral's output value and output enable then drive the pad, and the qualified pad input is passed back to that peripheral alone. The peripheral input slots that are not selected are held at 0.

Software uses a small register port to write the data latch, the direction latch and the packed function selects. Alongside that port sit three mask inputs that set, clear or toggle data-latch bits atomically. A read of the data address does not return the latch. It returns the live pad level, so a single address serves as the output latch on write and as the pin sampler on read. A low output enable means the pad is high impedance. The pad itself is outside the block and sees this as a separate enable output.

Top module: `gpio_pinmux_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the data latch, the direction latch and every function select clear to zero. After reset every pin is therefore a GPIO input with `pad_oe` = 0 and `pad_out` = 0.
- R2: A pin whose select is 00 drives `pad_out` from its data-latch bit and `pad_oe` from its direction-latch bit, where 1 means output.
- R3: The select of pin p is held in `wr_data[2p+1:2p]` of the mux register. Codes 01, 10 and 11 pick peripherals 1, 2 and 3. For peripheral index f (f = code−1), `pad_out[p]` = `per_out[f*NUM_PINS+p]` and `pad_oe[p]` = `per_oe[f*NUM_PINS+p]`.
- R4: `per_in[f*NUM_PINS+p]` equals `pad_in[p]` when pin p selects peripheral f+1. Otherwise it is 0, including whenever the pin is in GPIO mode.
- R5: A write with `wr_addr` = 0 (the data address) loads `wr_data[NUM_PINS-1:0]` into the data latch. The new value is visible at the pads from the next cycle.
- R6: A 1 in `set_mask` forces that latch bit to 1, a 1 in `clr_mask` forces it to 0, and a 1 in `tgl_mask` inverts it. Mask bits at 0 leave the latch bit unchanged.
- R7: The operations in one cycle are applied in a fixed order: direct write first, then set, then clear, then toggle. The result is ((base | set) & ~clr) ^ tgl, where base is either the written value or the old latch.
- R8: `rd_data` is combinational from `rd_addr`. Address 0 returns `pad_in`, zero-extended, whatever the latch or mode holds. Address 1 returns the direction latch, zero-extended. Address 2 returns the packed selects. Address 3 returns 0.
- R9: Writes to address 1 load the direction latch from `wr_data[NUM_PINS-1:0]`. Writes to address 2 load all selects from `wr_data`. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 direction, 2 function select, 3 reserved |
| wr_data | input | 2*NUM_PINS | Write data |
| set_mask | input | NUM_PINS | Data-latch bits to set |
| clr_mask | input | NUM_PINS | Data-latch bits to clear |
| tgl_mask | input | NUM_PINS | Data-latch bits to invert |
| rd_addr | input | 2 | Read address |
| rd_data | output | 2*NUM_PINS | Read data |
| pad_in | input | NUM_PINS | Qualified pad input levels |
| pad_out | output | NUM_PINS | Value to drive on each pad |
| pad_oe | output | NUM_PINS | Pad output enable, 0 = high impedance |
| per_out | input | 3*NUM_PINS | Peripheral output values, slot f at bits f*NUM_PINS |
| per_oe | input | 3*NUM_PINS | Peripheral output enables, same packing |
| per_in | output | 3*NUM_PINS | Pad input routed to the selected peripheral, same packing |

## Verification
The data latch cannot be observed while a pin belongs to a peripheral. Its only path to the ports is `pad_out` in GPIO mode, because reads of the data address return the pad. The stimulus therefore moves pins into peripheral modes, applies direct writes and toggles to the hidden latch, and then returns the pins to GPIO. At that point the latch value is compared against the model. Cycles that combine a direct write with set, clear and toggle masks overlapping on the same bits are driven on purpose, since random traffic seldom produces them. They check the ordering rule.

// File: rtl/gpio_mux_pkg.sv
// Package: shared encodings for the GPIO pin multiplexer bank.
// Assumes a 2-bit function select per pin and a 2-bit register address.
package gpio_mux_pkg;

    localparam int SEL_W  = 2;
    localparam int ADDR_W = 2;

    // Function select codes; 00 is plain GPIO and the reset default.
    typedef enum logic [SEL_W-1:0] {
        FN_GPIO = 2'b00,
        FN_PER1 = 2'b01,
        FN_PER2 = 2'b10,
        FN_PER3 = 2'b11
    } pin_fn_e;

    // Register addresses.
    localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] REG_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MUX  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_RSVD = 2'd3;

endpackage

// File: rtl/gpio_data_regs.sv
// Module: gpio_data_regs
// Holds the data latch, the direction latch and the packed function selects.
// A direct data write is merged first, then the set, clear and toggle masks,
// in that order. Assumes synchronous active-low reset.
module gpio_data_regs
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int BUS_W   = SEL_W * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic [NUM_PINS-1:0] tgl_mask,
    output logic [NUM_PINS-1:0] data_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [BUS_W-1:0]    mux_q
);

    logic [NUM_PINS-1:0] data_base;
    logic [NUM_PINS-1:0] data_d;
    logic                wr_data_hit;
    logic                wr_dir_hit;
    logic                wr_mux_hit;

    // Decode which register the write port addresses.
    always_comb begin
        wr_data_hit = wr_en && (wr_addr == REG_DATA);
        wr_dir_hit  = wr_en && (wr_addr == REG_DIR);
        wr_mux_hit  = wr_en && (wr_addr == REG_MUX);
    end

    // Merge the direct write, then set, clear and toggle, into the next latch value.
    always_comb begin
        data_base = wr_data_hit ? wr_data[NUM_PINS-1:0] : data_q;
        data_d    = ((data_base | set_mask) & ~clr_mask) ^ tgl_mask;
    end

    // Data latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    // Direction latch register.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_q <= '0;
        else if (wr_dir_hit) dir_q <= wr_data[NUM_PINS-1:0];
    end

    // Packed function-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)          mux_q <= '0;
        else if (wr_mux_hit) mux_q <= wr_data;
    end

endmodule

// File: rtl/gpio_pin_mux.sv
// Module: gpio_pin_mux
// One pin's multiplexer. It picks the pad output and the enable from the GPIO
// latches or from one peripheral, and routes the pad input only to the
// selected peripheral slot. Purely combinational.
module gpio_pin_mux
    import gpio_mux_pkg::*;
#(
    parameter int NUM_FUNC = 3
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic                data_bit,
    input  logic                dir_bit,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic                pad_in_bit,
    output logic                pad_out_bit,
    output logic                pad_oe_bit,
    output logic [NUM_FUNC-1:0] fn_in
);

    // Choose the source of the pad value and the enable for this pin.
    always_comb begin
        pad_out_bit = data_bit;
        pad_oe_bit  = dir_bit;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (sel == SEL_W'(f + 1)) begin
                pad_out_bit = fn_out[f];
                pad_oe_bit  = fn_oe[f];
            end
        end
    end

    // Give the pad input only to the peripheral slot currently selected.
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_route_in
        assign fn_in[f] = (sel == SEL_W'(f + 1)) & pad_in_bit;
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: gpio_read_mux
// Combinational read port. The data address samples the live pad levels, not
// the latch. The reserved address reads as zero.
module gpio_read_mux
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int BUS_W   = SEL_W * NUM_PINS
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [BUS_W-1:0]    mux_q,
    output logic [BUS_W-1:0]    rd_data
);

    // Select the read source by address.
    always_comb begin
        case (rd_addr)
            REG_DATA: rd_data = BUS_W'(pad_in);
            REG_DIR:  rd_data = BUS_W'(dir_q);
            REG_MUX:  rd_data = mux_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pinmux_bank.sv
// Module: gpio_pinmux_bank (top)
// A bank of NUM_PINS pins. Each pin is either GPIO (data and direction latches)
// or one of three peripheral functions. Peripheral buses are packed with slot f
// at bits [f*NUM_PINS +: NUM_PINS]. Assumes pad_in is already qualified.
module gpio_pinmux_bank
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    localparam int NUM_FUNC = (1 << SEL_W) - 1,
    localparam int BUS_W    = SEL_W * NUM_PINS,
    localparam int FN_W     = NUM_FUNC * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic [NUM_PINS-1:0] tgl_mask,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BUS_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [FN_W-1:0]     per_out,
    input  logic [FN_W-1:0]     per_oe,
    output logic [FN_W-1:0]     per_in
);

    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [BUS_W-1:0]    mux_q;

    gpio_data_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .tgl_mask (tgl_mask),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .mux_q    (mux_q)
    );

    // One multiplexer per pin; gather that pin's bit from each peripheral slot.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NUM_FUNC-1:0] pin_fn_out;
        logic [NUM_FUNC-1:0] pin_fn_oe;
        logic [NUM_FUNC-1:0] pin_fn_in;

        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_slot
            assign pin_fn_out[f]          = per_out[f*NUM_PINS + p];
            assign pin_fn_oe[f]           = per_oe[f*NUM_PINS + p];
            assign per_in[f*NUM_PINS + p] = pin_fn_in[f];
        end

        gpio_pin_mux #(.NUM_FUNC(NUM_FUNC)) u_pin (
            .sel         (mux_q[SEL_W*p +: SEL_W]),
            .data_bit    (data_q[p]),
            .dir_bit     (dir_q[p]),
            .fn_out      (pin_fn_out),
            .fn_oe       (pin_fn_oe),
            .pad_in_bit  (pad_in[p]),
            .pad_out_bit (pad_out[p]),
            .pad_oe_bit  (pad_oe[p]),
            .fn_in       (pin_fn_in)
        );
    end

    gpio_read_mux #(.NUM_PINS(NUM_PINS)) u_read (
        .rd_addr (rd_addr),
        .pad_in  (pad_in),
        .dir_q   (dir_q),
        .mux_q   (mux_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/gpio_pinmux_bank_chk.sv
// Module: gpio_pinmux_bank_chk
// Property checker bound into gpio_pinmux_bank. It relates the latch state,
// the write port and the pad-side outputs over time.
module gpio_pinmux_bank_chk
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    localparam int NUM_FUNC = (1 << SEL_W) - 1,
    localparam int BUS_W    = SEL_W * NUM_PINS,
    localparam int FN_W     = NUM_FUNC * NUM_PINS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [NUM_PINS-1:0] wr_lo,
    input logic [NUM_PINS-1:0] set_mask,
    input logic [NUM_PINS-1:0] clr_mask,
    input logic [NUM_PINS-1:0] tgl_mask,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [BUS_W-1:0]    rd_data,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [FN_W-1:0]     per_out,
    input logic [FN_W-1:0]     per_oe,
    input logic [FN_W-1:0]     per_in,
    input logic [NUM_PINS-1:0] data_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [BUS_W-1:0]    mux_q
);

    logic data_wr;
    logic no_mask;

    // Qualifiers shared by the latch-update properties.
    always_comb begin
        data_wr = wr_en && (wr_addr == REG_DATA);
        no_mask = (set_mask == '0) && (clr_mask == '0) && (tgl_mask == '0);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && dir_q == '0 && mux_q == '0));

    a_r5_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && no_mask) |=> data_q == $past(wr_lo));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && no_mask) |=> $stable(data_q));

    a_r6_toggle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && set_mask == '0 && clr_mask == '0 && tgl_mask != '0)
        |=> data_q == ($past(data_q) ^ $past(tgl_mask)));

    a_r9_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_RSVD) |=> ($stable(dir_q) && $stable(mux_q)));

    a_r8_read_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_DATA) |-> rd_data == BUS_W'(pad_in));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        a_r2_gpio_path: assert property (@(posedge clk) disable iff (!rst_n)
            (mux_q[SEL_W*p +: SEL_W] == FN_GPIO)
            |-> (pad_out[p] == data_q[p] && pad_oe[p] == dir_q[p]));

        a_r4_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({per_in[2*NUM_PINS + p], per_in[NUM_PINS + p], per_in[p]}));

        for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn_chk
            a_r3_periph_path: assert property (@(posedge clk) disable iff (!rst_n)
                (mux_q[SEL_W*p +: SEL_W] == SEL_W'(f + 1))
                |-> (pad_out[p] == per_out[f*NUM_PINS + p]
                     && pad_oe[p] == per_oe[f*NUM_PINS + p]));
        end
    end

endmodule

bind gpio_pinmux_bank gpio_pinmux_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lo    (wr_data[NUM_PINS-1:0]),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .tgl_mask (tgl_mask),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .per_out  (per_out),
    .per_oe   (per_oe),
    .per_in   (per_in),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .mux_q    (mux_q)
);

// File: tb/gpio_pinmux_bank_tb.sv
// Bench for gpio_pinmux_bank. A behavioural model of the latches is advanced
// on every clock and compared with all outputs half a cycle after each edge.
module gpio_pinmux_bank_tb;

    localparam int N  = 8;
    localparam int NF = 3;
    localparam int BW = 2 * N;
    localparam int FW = NF * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [N-1:0]  set_mask = '0, clr_mask = '0, tgl_mask = '0;
    logic [1:0]    rd_addr = '0;
    logic [BW-1:0] rd_data;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe;
    logic [FW-1:0] per_out = '0, per_oe = '0;
    logic [FW-1:0] per_in;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Reference state.
    logic [N-1:0]  m_data = '0;
    logic [N-1:0]  m_dir  = '0;
    logic [BW-1:0] m_mux  = '0;

    always #5 clk = ~clk;

    gpio_pinmux_bank #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .set_mask(set_mask), .clr_mask(clr_mask),
        .tgl_mask(tgl_mask), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model; tag names the GPIO-path requirement.
    task automatic check_all(input string tag);
        logic [FW-1:0] e_in;
        logic [BW-1:0] e_rd;
        #1;
        e_in = '0;
        for (int p = 0; p < N; p++) begin
            int code = int'(m_mux[2*p +: 2]);
            if (code == 0) begin
                check(tag, $sformatf("pad_out[%0d]", p), 32'(pad_out[p]), 32'(m_data[p]));
                check(tag, $sformatf("pad_oe[%0d]", p),  32'(pad_oe[p]),  32'(m_dir[p]));
            end else begin
                check("R3", $sformatf("pad_out[%0d]", p), 32'(pad_out[p]), 32'(per_out[(code-1)*N + p]));
                check("R3", $sformatf("pad_oe[%0d]", p),  32'(pad_oe[p]),  32'(per_oe[(code-1)*N + p]));
                e_in[(code-1)*N + p] = pad_in[p];
            end
        end
        check("R4", "per_in", 32'(per_in), 32'(e_in));
        case (rd_addr)
            2'd0:    e_rd = BW'(pad_in);
            2'd1:    e_rd = BW'(m_dir);
            2'd2:    e_rd = m_mux;
            default: e_rd = '0;
        endcase
        check("R8", "rd_data", 32'(rd_data), 32'(e_rd));
    endtask

    // Check, then advance DUT and model across one clock edge.
    task automatic tick(input string tag);
        logic [N-1:0]  base, nd, ndir;
        logic [BW-1:0] nmux;
        check_all(tag);
        base = (wr_en && wr_addr == 2'd0) ? wr_data[N-1:0] : m_data;
        nd   = ((base | set_mask) & ~clr_mask) ^ tgl_mask;
        ndir = (wr_en && wr_addr == 2'd1) ? wr_data[N-1:0] : m_dir;
        nmux = (wr_en && wr_addr == 2'd2) ? wr_data : m_mux;
        @(posedge clk);
        m_data = nd; m_dir = ndir; m_mux = nmux;
        @(negedge clk);
    endtask

    task automatic drive(input logic we, input logic [1:0] a, input logic [BW-1:0] d,
                         input logic [N-1:0] s, input logic [N-1:0] c, input logic [N-1:0] t);
        wr_en = we; wr_addr = a; wr_data = d; set_mask = s; clr_mask = c; tgl_mask = t;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, '0, '0, '0, '0);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog: an unfinished run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        pad_in = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every pin a GPIO input.
        idle();
        tick("R1");
        check("R1", "pad_oe", 32'(pad_oe), 32'h0);
        check("R1", "pad_out", 32'(pad_out), 32'h0);

        // R9: direction write; R8 read it back.
        drive(1'b1, 2'd1, 16'h00FF, '0, '0, '0); tick("R9");
        idle(); rd_addr = 2'd1; tick("R9");

        // R5: direct data write.
        drive(1'b1, 2'd0, 16'h00A5, '0, '0, '0); tick("R5");
        idle(); rd_addr = 2'd0; tick("R5");
        check("R5", "pad_out", 32'(pad_out), 32'hA5);

        // R6: set, clear and toggle each alone.
        drive(1'b0, 2'd0, '0, 8'h0F, '0, '0); tick("R6");
        idle(); tick("R6");
        check("R6", "pad_out after set", 32'(pad_out), 32'hAF);
        drive(1'b0, 2'd0, '0, '0, 8'hA0, '0); tick("R6");
        idle(); tick("R6");
        check("R6", "pad_out after clear", 32'(pad_out), 32'h0F);
        drive(1'b0, 2'd0, '0, '0, '0, 8'hFF); tick("R6");
        idle(); tick("R6");
        check("R6", "pad_out after toggle", 32'(pad_out), 32'hF0);

        // R7: write plus all masks in one cycle; then set and clear on one bit.
        drive(1'b1, 2'd0, 16'h0033, 8'h80, 8'h01, 8'h04); tick("R7");
        idle(); tick("R7");
        check("R7", "merged pad_out", 32'(pad_out), 32'hB6);
        drive(1'b0, 2'd0, '0, 8'h10, 8'h10, 8'h00); tick("R7");
        idle(); tick("R7");
        check("R7", "clear after set", 32'(pad_out), 32'hA6);

        // R8: data address reads the pad, not the latch.
        pad_in = 8'h3C; rd_addr = 2'd0; tick("R8");
        check("R8", "rd_data pad level", 32'(rd_data), 32'h003C);

        // R9: reserved address write has no effect; reserved read is zero.
        drive(1'b1, 2'd3, 16'hFFFF, '0, '0, '0); tick("R9");
        idle(); rd_addr = 2'd3; tick("R9");
        rd_addr = 2'd1; tick("R9");
        rd_addr = 2'd2; tick("R9");

        // R3/R4: mixed functions across pins, varied peripheral drive.
        drive(1'b1, 2'd2, 16'hE4E4, '0, '0, '0); tick("R9");
        idle();
        for (int i = 0; i < 8; i++) begin
            per_out = FW'($urandom); per_oe = FW'($urandom); pad_in = N'($urandom);
            rd_addr = 2'(i);
            tick("R3");
        end

        // Hidden latch: update while pins belong to peripherals, then return to GPIO.
        drive(1'b1, 2'd0, 16'h003C, '0, '0, '0); tick("R5");
        drive(1'b0, 2'd0, '0, '0, '0, 8'hFF); tick("R6");
        drive(1'b1, 2'd2, 16'h0000, '0, '0, '0); tick("R9");
        idle(); tick("R5");
        check("R5", "latch kept through peripheral mode", 32'(pad_out), 32'hC3);

        // Random traffic mixing every operation.
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 10);
            logic [1:0] a = (r == 0) ? 2'd2 : 2'($urandom % 4);
            if (a == 2'd2) a = (r == 0) ? 2'd2 : 2'd0;
            drive(1'($urandom), a, BW'($urandom), N'($urandom), N'($urandom), N'($urandom));
            if ($urandom % 2 == 0) begin set_mask = '0; clr_mask = '0; end
            per_out = FW'($urandom); per_oe = FW'($urandom); pad_in = N'($urandom);
            rd_addr = 2'($urandom);
            tick("R2");
        end
        idle(); tick("R2");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule